// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns characters into a framed asynchronous bit stream on a single output line. It pulls each character from an upstream holding register or FIFO through a valid/ready pop handshake. Each bit is timed by a 16x oversampling tick that comes from a separate baud generator. The character format is set by line-control inputs: the data length (5 to 8 bits), the parity mode (none, even, odd, or a parity bit held at a fixed level), and one or two stop bits.

Several controls decide whether a new character may start: a global enable, a transmit enable, optional clear-to-send flow control and a send-break request. None of them cuts short a character already on the line. Once a character starts, it always runs to its last stop bit. A break request then holds the line low after that character. The busy output reports pending or in-flight work to the register layer.

Top module: `uart_tx_serializer`

## Requirements
- R1: A character is sent as a low start bit, then the data bits least significant first, then the parity bit when enabled, then the stop bits, which are high.
- R2: `word_len` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Unused high data bits are not sent.
- R3: Parity is set by {par_en, par_even, par_stick}. With par_en=0 no parity bit is sent. The combination 1,1,0 gives even parity over the sent data bits. The combination 1,0,0 gives odd parity. The combination 1,0,1 sends a constant 1. The combination 1,1,1 sends a constant 0.
- R4: `two_stop`=1 appends two stop bits. `two_stop`=0 appends one.
- R5: Every bit lasts exactly OSR (default 16) cycles in which `tick` is high. With `tick` high on every cycle, a frame of N bits keeps `busy` high for exactly 16*N cycles after the start, counted with no further pending data.
- R6: With `send_break`=1, `txd` is driven low once any character in progress has finished. No new character starts while `send_break` is 1.
- R7: `busy` is high whenever `data_valid` is high, whatever the enables are. It stays high until the last stop bit has ended, and then falls if nothing is pending.
- R8: With `cts_flow_en`=1, a character starts only while the active-low `cts_n` is 0. With `cts_flow_en`=0, `cts_n` is ignored.
- R9: A character starts only when `glob_en` and `tx_en` are both 1. Clearing either of them mid-character still lets that character complete unchanged.
- R10: `txd` is high whenever no character is being sent and `send_break` is 0, including right after reset.
- R11: `data_ready` is high for the cycle in which a pending character is accepted. It is never high while a character is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling tick, OSR per bit |
| data_valid | input | 1 | A character is pending upstream |
| data | input | 8 | Pending character |
| data_ready | output | 1 | Pop strobe: the character is taken this cycle |
| word_len | input | 2 | Data-length code |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even-parity select |
| par_stick | input | 1 | Fixed-level parity select |
| two_stop | input | 1 | Two stop bits |
| send_break | input | 1 | Hold the line low after the current character |
| glob_en | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| cts_flow_en | input | 1 | Clear-to-send flow-control enable |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| busy | output | 1 | Work pending or in flight |

## Verification
The assertions assume that `data_valid` and `data` are held steady until `data_ready` accepts the character, as a FIFO pop interface does. They also assume that the line-control fields are changed only while `busy` is low. The bench keeps to both rules. It changes the format only between frames, and it alters the enables and the break request mid-frame only to exercise the completion rules. The main sweep covers every data length, every parity mode and both stop-bit counts. It holds `tick` high on every cycle so that expected bit positions are exact, and a separate slower-tick frame checks the frame length against a tolerance window.

// File: rtl/uart_tx_serializer.sv
`timescale 1ns/1ps
module uart_tx_serializer #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       data_valid,
  input  logic [7:0] data,
  output logic       data_ready,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       two_stop,
  input  logic       send_break,
  input  logic       glob_en,
  input  logic       tx_en,
  input  logic       cts_flow_en,
  input  logic       cts_n,
  output logic       txd,
  output logic       busy
);
  localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int FW = 12;
  localparam int NW = $clog2(FW + 1);

  logic          active;
  logic [TW-1:0] tcnt;
  logic [NW-1:0] left;
  logic [FW-1:0] sh;
  logic [FW-1:0] frame;
  logic [NW-1:0] flen;
  logic [3:0]    dlen;
  logic [7:0]    dmask;
  logic          pbit;
  logic          go;

  always_comb begin
    dlen  = 4'd5 + {2'b00, word_len};
    dmask = 8'hFF >> (4'd8 - dlen);
    if (par_stick) pbit = ~par_even;
    else           pbit = par_even ? ^(data & dmask) : ~^(data & dmask);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(dlen)) frame[i+1] = data[i];
    if (par_en) frame[dlen + 4'd1] = pbit;
    flen = NW'(dlen) + NW'(2) + NW'(par_en) + NW'(two_stop);
  end

  assign go = !active && data_valid && glob_en && tx_en && !send_break &&
              (!cts_flow_en || !cts_n);
  assign data_ready = go;
  assign busy = active | data_valid;
  assign txd  = active ? sh[0] : ~send_break;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tcnt   <= '0;
      left   <= '0;
      sh     <= '1;
    end else if (go) begin
      active <= 1'b1;
      tcnt   <= '0;
      left   <= flen;
      sh     <= frame;
    end else if (active && tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - NW'(1);
        if (left == NW'(1)) active <= 1'b0;
      end else begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end
endmodule

module uart_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic data_valid,
  input logic data_ready,
  input logic glob_en,
  input logic tx_en,
  input logic cts_flow_en,
  input logic cts_n,
  input logic send_break,
  input logic txd,
  input logic busy
);
  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !send_break) |-> txd);
  assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && send_break) |-> !txd);
  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !txd);
  assert_pop_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> busy);
  assert_cts_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && cts_flow_en) |-> !cts_n);
  assert_enable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (glob_en && tx_en && data_valid));
  assert_no_back_to_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);
endmodule

bind uart_tx_serializer uart_tx_serializer_chk u_chk (.*);

// File: tb/tb_uart_tx_serializer.sv
`timescale 1ns/1ps
module tb_uart_tx_serializer;
  logic clk = 0, rst_n = 0, tick = 1, dv = 0;
  logic [7:0] d = 0;
  logic [1:0] wl = 0;
  logic pe = 0, ev = 0, st = 0, ts = 0, brk = 0, ge = 1, te = 1, cfe = 0, ctsn = 1;
  logic data_ready, txd, busy;
  int nchk = 0, nerr = 0;
  bit slow = 0, done = 0;
  int tc = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (slow) begin tc = (tc + 1) % 3; tick = (tc == 0); end
    else tick = 1;
  end

  uart_tx_serializer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .data_valid(dv), .data(d),
    .data_ready(data_ready), .word_len(wl), .par_en(pe), .par_even(ev),
    .par_stick(st), .two_stop(ts), .send_break(brk), .glob_en(ge),
    .tx_en(te), .cts_flow_en(cfe), .cts_n(ctsn), .txd(txd), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len();
    return 1 + 5 + int'(wl) + int'(pe) + 1 + int'(ts);
  endfunction

  function automatic logic exp_bit(input int k, input logic [7:0] dd);
    int dl = 5 + int'(wl);
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= dl) return dd[k-1];
    if (pe && k == dl + 1) begin
      if (st) return ~ev;
      for (int i = 0; i < dl; i++) ones += int'(dd[i]);
      return ev ? logic'(ones % 2) : logic'((ones + 1) % 2);
    end
    return 1'b1;
  endfunction

  task automatic start_char(input logic [7:0] dd);
    @(negedge clk); d = dd; dv = 1; #1;
    while (!data_ready) begin @(negedge clk); #1; end
    @(negedge clk); dv = 0;
  endtask

  task automatic frame(input logic [7:0] dd, input string req,
                       input int dis_at, input int brk_at);
    int n = exp_len();
    int badk = -1;
    logic ea = 0, eb = 0;
    start_char(dd);
    repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (16) @(negedge clk);
      if (k == dis_at) te = 0;
      if (k == brk_at) brk = 1;
      if (badk < 0 && txd !== exp_bit(k, dd)) begin badk = k; ea = txd; eb = exp_bit(k, dd); end
    end
    chk(badk < 0, {req, " frame bits"}, badk < 0 ? 0 : int'(ea), badk < 0 ? 0 : int'(eb));
    repeat (7) @(negedge clk);
    chk(busy === 1'b1, "R7 busy through last stop bit", int'(busy), 1);
    @(negedge clk);
    chk(busy === 1'b0, "R5 frame length 16*N", int'(busy), 0);
    chk(txd === ~brk, brk ? "R6 break after char" : "R10 idle mark", int'(txd), int'(~brk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && data_ready === 1'b0, "R10 reset state",
        int'({txd, busy, data_ready}), 4);
    rst_n = 1;
    @(negedge clk);

    // R1 R2 R3 R4 sweep over every format
    for (int w = 0; w < 4; w++)
      for (int pm = 0; pm < 5; pm++)
        for (int s = 0; s < 2; s++) begin
          wl = 2'(w); ts = 1'(s);
          pe = (pm != 0); ev = (pm == 1 || pm == 4); st = (pm >= 3);
          frame(8'hA5, "R1 R2 R3 R4", -1, -1);
          frame(8'h3C ^ 8'(w * 5 + pm), "R1 R2 R3 R4", -1, -1);
        end
    wl = 2'b11; pe = 0; ts = 0;
    frame(8'h00, "R1 zeros", -1, -1);
    frame(8'hFF, "R1 ones", -1, -1);

    // R8 CTS gating
    cfe = 1; ctsn = 1;
    @(negedge clk); d = 8'h5A; dv = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); #1; if (data_ready) seen++; end
      chk(seen == 0, "R8 no start while cts_n high", seen, 0);
      chk(txd === 1'b1, "R8 line idle while blocked", int'(txd), 1);
      chk(busy === 1'b1, "R7 busy while pending", int'(busy), 1);
    end
    dv = 0; ctsn = 0;
    frame(8'h5A, "R8 start with cts_n low", -1, -1);
    cfe = 0; ctsn = 1;
    frame(8'h96, "R8 cts_n ignored when disabled", -1, -1);

    // R9 enable gating and graceful completion
    ge = 0;
    @(negedge clk); d = 8'hC3; dv = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); #1; if (data_ready) seen++; end
      chk(seen == 0 && txd === 1'b1, "R9 no start when disabled", seen, 0);
      chk(busy === 1'b1, "R7 busy pending while disabled", int'(busy), 1);
    end
    dv = 0; ge = 1;
    frame(8'hC3, "R9 completes after tx_en cleared", 3, -1);
    @(negedge clk); d = 8'h11; dv = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (data_ready) seen++; end
      chk(seen == 0, "R9 stays stopped after disable", seen, 0);
    end
    dv = 0; te = 1;

    // R6 break after current character, no start during break
    frame(8'h69, "R6 char completes under break", 4, 2);
    te = 1;
    @(negedge clk); d = 8'h22; dv = 1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (data_ready) seen++; end
      chk(seen == 0 && txd === 1'b0, "R6 held low, no start", seen + int'(txd), 0);
    end
    dv = 0; brk = 0;
    @(negedge clk);
    chk(txd === 1'b1, "R10 mark after break released", int'(txd), 1);

    // R11 single-cycle pop strobe
    begin
      int pops = 0;
      @(negedge clk); d = 8'h81; dv = 1;
      for (int i = 0; i < 200; i++) begin @(negedge clk); #1; if (data_ready) pops++; end
      dv = 0;
      chk(pops == 1, "R11 one pop per character", pops, 1);
      while (busy) @(negedge clk);
    end

    // R5 sparse tick: frame length scales with tick rate
    slow = 1; wl = 2'b11; pe = 0; ts = 0;
    begin
      int cnt = 0;
      start_char(8'h47);
      while (busy && cnt < 5000) begin @(negedge clk); cnt++; end
      chk(cnt >= 16 * 10 * 3 - 3 && cnt <= 16 * 10 * 3 + 3, "R5 bit time follows tick", cnt, 480);
    end
    slow = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule